// File: doc/BRIEF.md
# Interrupt Request Test Override Bank

This block sits between the interrupt request lines of a chip and its interrupt prioritizer. In normal operation it passes the live request vector straight through. For test, it holds a bank of 8-bit override registers, one for each group of eight request lines. Software selects one register at a time through a 4-bit index in a small control register. All override registers are reached through one shared data address.

When the chip is in special (test) mode and the override bit in the control register is set, the live lines are cut off from the prioritizer. The prioritizer then sees only the override register contents. In that state software can write a chosen pattern and watch how the priority logic resolves it. With the override bit clear, software can read a group of live request lines to confirm that a peripheral's request arrives. Writes to the override registers are accepted only when the CPU has interrupts masked, so forced requests cannot be taken while they are being set up.

The group at index 15 holds only three request lines. Index values above the number of built groups select nothing.

Top module: `irq_test_bank`

## Requirements
- R1: After reset the override bit is 0, the index is 0 and every override register holds zero.
- R2: The control register (bus_sel = 0) keeps the override bit in bit 7 and the index in bits 3:0, and reads as 0 in bits 6:4. It can be read at any time. A write changes it only in special mode.
- R3: While special mode is off or the override bit is 0, req_out equals req_in.
- R4: While special mode is on and the override bit is 1, req_out equals the override register contents, and req_in has no effect on it.
- R5: A write to the override register (bus_sel = 1) lands in the indexed register only when special mode is on, the override bit is 1 and irq_mask is 1. In every other case the write is dropped.
- R6: In special mode, reading bus_sel = 1 returns the indexed group of live req_in lines when the override bit is 0, and the stored override register when it is 1.
- R7: Outside special mode, every read with bus_sel = 1 returns 0x00.
- R8: At index 15 only bits 2:0 exist. Bits 7:3 read as 0 and writes to them are dropped.
- R9: An index at or above NUM_BANKS reads as 0x00, and a write to it changes no override register.
- R10: Clearing special_mode returns req_out to req_in within the same cycle, with no clock edge needed.
- R11: Bit n of override register k drives req_out line 8k+n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Chip is in special (test) mode |
| irq_mask | input | 1 | CPU interrupt-mask bit (1 = interrupts masked) |
| req_in | input | REQ_W | Live interrupt request lines |
| bus_sel | input | 1 | Register select: 0 = control, 1 = override data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| req_out | output | REQ_W | Request vector passed to the prioritizer |

## Verification
The bench targets the three conditions that gate a write. It tries an override write with the mask clear, an override write after leaving special mode while the override bit is still set, and a control write in normal mode. A design that checked only one of these would accept a stray write, and a later read-back would show it. The bench also checks that req_out returns to the live lines as soon as special mode drops. A design that relied on a register to clear the override would show forced requests for one extra cycle. The truncated group at index 15 is written with all ones. A second instance with twelve groups then has unbuilt indices written and read. A design that aliased those indices onto a built register would return nonzero data or corrupt another group's forced request bits.

// File: rtl/irq_test_pkg.sv
package irq_test_pkg;

  localparam int unsigned BANK_W    = 8;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned TRUNC_IDX = 15;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_TEST = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic             ovr;
    logic [IDX_W-1:0] idx;
  } ctrl_t;

  // width of the group at index k
  function automatic int unsigned bank_bits(int unsigned k, int unsigned trunc);
    return (k == TRUNC_IDX) ? trunc : BANK_W;
  endfunction

  // total request width for nb groups
  function automatic int unsigned req_width(int unsigned nb, int unsigned trunc);
    int unsigned sum;
    sum = 0;
    for (int unsigned k = 0; k < nb; k++) sum += bank_bits(k, trunc);
    return sum;
  endfunction

endpackage

// File: rtl/irq_test_ctrl.sv
module irq_test_ctrl
  import irq_test_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output ctrl_t       ctrl_q
);

  ctrl_t ctrl_d;
  logic  unused_wbits;

  assign unused_wbits = ^wdata[6:4];

  always_comb begin
    ctrl_d     = ctrl_q;
    ctrl_d.ovr = wdata[7];
    ctrl_d.idx = wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/irq_test_banks.sv
module irq_test_banks
  import irq_test_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 16,
  parameter int unsigned TRUNC_BITS = 3,
  parameter int unsigned REQ_W      = req_width(NUM_BANKS, TRUNC_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wdata,
  output logic [REQ_W-1:0] test_vec,
  output logic [7:0]       bank_q [NUM_BANKS]
);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam int unsigned W   = bank_bits(k, TRUNC_BITS);
    localparam int unsigned OFS = BANK_W * k;

    logic         hit;
    logic [W-1:0] q;
    logic [W-1:0] d;
    logic [7:0]   ext;

    assign hit = wr_en && (wr_idx == IDX_W'(k));

    always_comb begin
      d = q;
      if (hit) d = wdata[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= d;
      end
    end

    always_comb begin
      ext        = '0;
      ext[W-1:0] = q;
    end

    assign test_vec[OFS +: W] = q;
    assign bank_q[k]          = ext;
  end

endmodule

// File: rtl/irq_test_rdmux.sv
module irq_test_rdmux
  import irq_test_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 16,
  parameter int unsigned TRUNC_BITS = 3,
  parameter int unsigned REQ_W      = req_width(NUM_BANKS, TRUNC_BITS)
) (
  input  logic             special_mode,
  input  logic             bus_sel,
  input  ctrl_t            ctrl,
  input  logic [REQ_W-1:0] req_in,
  input  logic [REQ_W-1:0] test_vec,
  input  logic [7:0]       bank_q [NUM_BANKS],
  output logic [7:0]       bus_rdata,
  output logic [REQ_W-1:0] req_out
);

  logic [7:0] live_ext [NUM_BANKS];
  logic [7:0] test_rd;
  logic [7:0] ctrl_rd;
  logic       ovr_act;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_live
    localparam int unsigned W   = bank_bits(k, TRUNC_BITS);
    localparam int unsigned OFS = BANK_W * k;
    logic [7:0] ext;
    always_comb begin
      ext        = '0;
      ext[W-1:0] = req_in[OFS +: W];
    end
    assign live_ext[k] = ext;
  end

  // selected group; indices with no built group fall through as zero
  always_comb begin
    test_rd = '0;
    for (int k = 0; k < int'(NUM_BANKS); k++) begin
      if (special_mode && (ctrl.idx == IDX_W'(k))) begin
        test_rd = ctrl.ovr ? bank_q[k] : live_ext[k];
      end
    end
  end

  assign ctrl_rd   = {ctrl.ovr, 3'b000, ctrl.idx};
  assign bus_rdata = (bus_sel == SEL_TEST) ? test_rd : ctrl_rd;

  // special_mode gates the override combinationally
  assign ovr_act = special_mode && ctrl.ovr;
  assign req_out = ovr_act ? test_vec : req_in;

endmodule

// File: rtl/irq_test_bank.sv
module irq_test_bank
  import irq_test_pkg::*;
#(
  parameter  int unsigned NUM_BANKS  = 16,
  parameter  int unsigned TRUNC_BITS = 3,
  localparam int unsigned REQ_W      = req_width(NUM_BANKS, TRUNC_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_mode,
  input  logic             irq_mask,
  input  logic [REQ_W-1:0] req_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [REQ_W-1:0] req_out
);

  ctrl_t            ctrl_q;
  logic             ctrl_wr;
  logic             test_wr;
  logic [REQ_W-1:0] test_vec;
  logic [7:0]       bank_q [NUM_BANKS];

  assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL) && special_mode;
  assign test_wr = bus_wr && (bus_sel == SEL_TEST) && special_mode
                   && ctrl_q.ovr && irq_mask;

  irq_test_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  irq_test_banks #(
    .NUM_BANKS  (NUM_BANKS),
    .TRUNC_BITS (TRUNC_BITS),
    .REQ_W      (REQ_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (test_wr),
    .wr_idx   (ctrl_q.idx),
    .wdata    (bus_wdata),
    .test_vec (test_vec),
    .bank_q   (bank_q)
  );

  irq_test_rdmux #(
    .NUM_BANKS  (NUM_BANKS),
    .TRUNC_BITS (TRUNC_BITS),
    .REQ_W      (REQ_W)
  ) u_rdmux (
    .special_mode (special_mode),
    .bus_sel      (bus_sel),
    .ctrl         (ctrl_q),
    .req_in       (req_in),
    .test_vec     (test_vec),
    .bank_q       (bank_q),
    .bus_rdata    (bus_rdata),
    .req_out      (req_out)
  );

endmodule

// File: rtl/irq_test_bank_chk.sv
module irq_test_bank_chk #(
  parameter int unsigned REQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             special_mode,
  input logic             irq_mask,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_rdata,
  input logic [REQ_W-1:0] req_in,
  input logic [REQ_W-1:0] req_out,
  input logic [REQ_W-1:0] test_vec,
  input logic             ovr_q,
  input logic [3:0]       idx_q
);

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode || !ovr_q) |-> (req_out == req_in));

  // R4
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && ovr_q) |-> (req_out == test_vec));

  // R7
  normal_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && bus_sel) |-> (bus_rdata == 8'h00));

  // R5
  masked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && !irq_mask) |=> $stable(test_vec));

  // R2
  ctrl_normal_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && !special_mode) |=> $stable({ovr_q, idx_q}));

  // R8
  trunc_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && bus_sel && (idx_q == 4'hF)) |-> (bus_rdata[7:3] == 5'b0));

endmodule

bind irq_test_bank irq_test_bank_chk #(.REQ_W(REQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .irq_mask     (irq_mask),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_rdata    (bus_rdata),
  .req_in       (req_in),
  .req_out      (req_out),
  .test_vec     (test_vec),
  .ovr_q        (ctrl_q.ovr),
  .idx_q        (ctrl_q.idx)
);

// File: tb/irq_test_bank_tb.sv
module irq_test_bank_tb;

  localparam int WA = 123;  // 15 full groups + 3-bit group 15
  localparam int WB = 96;   // 12 full groups

  typedef struct {
    int           dut;   // 0 = u_dut, 1 = u_dut_part
    bit           vec;   // 1 = compare req_out, 0 = bus_rdata
    logic [127:0] exp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, special_mode, irq_mask, bus_sel, bus_wr;
  logic [7:0]    bus_wdata, rdata_a, rdata_b;
  logic [WA-1:0] req_in_a, req_out_a;
  logic [WB-1:0] req_in_b, req_out_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb [$];

  localparam logic [127:0] PAT = 128'h96F3_0C5A_E17B_24D8_3A6C_91F5_0B7E_C248;

  always #10 clk = ~clk;

  irq_test_bank u_dut (
    .clk (clk), .rst_n (rst_n), .special_mode (special_mode), .irq_mask (irq_mask),
    .req_in (req_in_a), .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
    .bus_rdata (rdata_a), .req_out (req_out_a)
  );

  irq_test_bank #(.NUM_BANKS(12), .TRUNC_BITS(3)) u_dut_part (
    .clk (clk), .rst_n (rst_n), .special_mode (special_mode), .irq_mask (irq_mask),
    .req_in (req_in_b), .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
    .bus_rdata (rdata_b), .req_out (req_out_b)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [127:0] act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      if (it.vec) act = (it.dut == 0) ? {5'b0, req_out_a} : {32'b0, req_out_b};
      else        act = (it.dut == 0) ? {120'b0, rdata_a} : {120'b0, rdata_b};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s dut=%0d actual=%h expected=%h", it.tag, it.dut, act, it.exp);
      end
    end
  end

  task automatic push(int dut, bit vec, logic [127:0] e, string tag);
    item_t it;
    it.dut = dut; it.vec = vec; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic write_reg(logic sel, logic [7:0] d);
    @(posedge clk); #2;
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic select(logic sel);
    @(posedge clk); #2;
    bus_sel = sel; bus_wr = 1'b0;
  endtask

  task automatic expect_rd(logic [7:0] ea, logic [7:0] eb, string tag);
    push(0, 1'b0, {120'b0, ea}, tag);
    push(1, 1'b0, {120'b0, eb}, tag);
  endtask

  task automatic expect_vec(logic [127:0] ea, logic [127:0] eb, string tag);
    push(0, 1'b1, ea, tag);
    push(1, 1'b1, eb, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; special_mode = 1'b0; irq_mask = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    req_in_a = PAT[WA-1:0]; req_in_b = PAT[WB-1:0];
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state of control and stored values
    special_mode = 1'b1;
    select(1'b0);
    expect_rd(8'h00, 8'h00, "R1 ctrl after reset"); settle();
    write_reg(1'b0, 8'h80);
    select(1'b1);
    expect_rd(8'h00, 8'h00, "R1 group 0 stored zero");
    expect_vec('0, '0, "R1 R4 forced vector zero, live ignored"); settle();
    write_reg(1'b0, 8'h00);

    // R3, R7, R2 in normal mode
    special_mode = 1'b0;
    select(1'b1);
    expect_vec({5'b0, PAT[WA-1:0]}, {32'b0, PAT[WB-1:0]}, "R3 passthrough");
    expect_rd(8'h00, 8'h00, "R7 normal mode read zero"); settle();
    write_reg(1'b0, 8'h85);
    select(1'b0);
    expect_rd(8'h00, 8'h00, "R2 ctrl write ignored in normal mode"); settle();

    // R2, R6 live read
    special_mode = 1'b1;
    write_reg(1'b0, 8'h05);
    select(1'b0);
    expect_rd(8'h05, 8'h05, "R2 ctrl readback"); settle();
    select(1'b1);
    expect_rd(PAT[47:40], PAT[47:40], "R6 live group read"); settle();

    // R5 masked write dropped, R4 forced vector
    write_reg(1'b0, 8'h85);
    irq_mask = 1'b0;
    write_reg(1'b1, 8'h3C);
    select(1'b1);
    expect_rd(8'h00, 8'h00, "R5 write with mask clear dropped");
    expect_vec('0, '0, "R4 forced vector replaces live"); settle();
    irq_mask = 1'b1;
    write_reg(1'b1, 8'h3C);
    select(1'b1);
    expect_rd(8'h3C, 8'h3C, "R5 R6 accepted write stored");
    expect_vec(128'h3C << 40, 128'h3C << 40, "R11 group 5 bit mapping"); settle();

    // R10 same-cycle release, R5 write outside special mode
    @(posedge clk); #2;
    special_mode = 1'b0;
    expect_vec({5'b0, PAT[WA-1:0]}, {32'b0, PAT[WB-1:0]}, "R10 release on leaving special mode");
    settle();
    write_reg(1'b1, 8'hFF);
    special_mode = 1'b1;
    select(1'b1);
    expect_rd(8'h3C, 8'h3C, "R5 write outside special mode dropped"); settle();

    // R8 truncated group, R9 unbuilt group
    write_reg(1'b0, 8'h8F);
    write_reg(1'b1, 8'hFF);
    select(1'b1);
    expect_rd(8'h07, 8'h00, "R8 R9 index 15 read");
    expect_vec((128'h3C << 40) | (128'h7 << 120), 128'h3C << 40,
               "R8 R9 index 15 forced bits"); settle();
    write_reg(1'b0, 8'h0F);
    select(1'b1);
    expect_rd({5'b0, PAT[122:120]}, 8'h00, "R6 R9 index 15 live read"); settle();
    write_reg(1'b0, 8'h0C);
    select(1'b1);
    expect_rd(PAT[103:96], 8'h00, "R9 index 12 live read"); settle();

    // R11 second pattern in group 0
    write_reg(1'b0, 8'h80);
    write_reg(1'b1, 8'h81);
    select(1'b1);
    expect_rd(8'h81, 8'h81, "R11 group 0 readback");
    expect_vec(128'h81 | (128'h3C << 40) | (128'h7 << 120), 128'h81 | (128'h3C << 40),
               "R11 group 0 bits 0 and 7"); settle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule